// File: doc/BRIEF.md
# Register-Operand Decode and Execute Stage

This block is the combinational decode and execute step of a small 32-bit load/store processor that has 32 general registers. It receives one instruction word and the two values the register file returned for the instruction's source fields. In the same cycle it produces the destination register index, a write strobe, the 32-bit value to write back and a trap indication with a 2-bit cause. The register file, the program counter, memory access and branching are handled by neighbouring blocks. This stage covers only field extraction, opcode classification, the arithmetic/logic unit and trap signalling.

The 6-bit opcode is grouped in octal. Its upper three bits select a class: register arithmetic, register logic, immediate move, or miscellaneous. The lower three bits select the operation within that class. Any opcode this stage does not implement is reported as illegal. A zero divisor for divide or remainder is reported as a divide-by-zero trap and writes no register. Register 0 always reads as zero and can never be written.

Top module: `risc_exec_stage`

## Requirements
- R1: Fields sit at fixed positions: opcode in bits 31:26, field a in 25:21, field b in 20:16, field c in 15:11 and the immediate in 15:0. A register-form operation writes register a and uses the values of registers b and c as its operands.
- R2: Opcodes 0, 1 and 2 perform add, subtract and multiply on unsigned 32-bit operands. Each wraps modulo 2^32, and multiply keeps the low 32 bits.
- R3: Opcodes 3 and 4 return the unsigned quotient and the unsigned remainder. When the divisor is zero, the stage raises trap cause 1 (divide-by-zero) and writes nothing.
- R4: Opcodes 5 and 6 shift operand b left or right by the low 5 bits of operand c. The right shift is logical and fills with zeros.
- R5: Opcodes 8, 9, 10 and 11 (octal 10 to 13) compute AND, OR, XOR and NOR of the operands, where NOR is the inverted OR.
- R6: Opcode 16 (octal 20) writes the immediate, sign-extended from bit 15, into register b.
- R7: A source field equal to 0 supplies the value zero, whatever value the register file presents for it.
- R8: The write strobe is never asserted for destination register 0. An operation aimed at register 0 has no visible effect.
- R9: Opcode 56 (octal 70) raises trap cause 2 (system call) and writes nothing.
- R10: Every other opcode raises trap cause 3 (illegal instruction) and writes nothing. Cause 0 is reserved for misaligned access, which this stage never raises.
- R11: While the write strobe is low, the result and the destination index read zero. While the trap flag is low, the trap cause reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode and execute |
| rs_b_val_i | input | 32 | Register file value for field b |
| rs_c_val_i | input | 32 | Register file value for field c |
| dst_idx_o | output | 5 | Destination register index, zero when not writing |
| wr_en_o | output | 1 | Register write strobe |
| result_o | output | 32 | Write-back value, zero when not writing |
| trap_o | output | 1 | Trap raised by this instruction |
| trap_cause_o | output | 2 | Trap cause: 0 misaligned, 1 divide-by-zero, 2 system call, 3 illegal |

## Verification
Two functions can act on the same instruction. A divide or remainder can meet a zero divisor while its destination is register 0, so the trap path and the register-0 write suppression both apply. A zero-divisor case can also come from the register-0 rule alone: field c is 0 while the register file presents a non-zero value for it. The bench builds these cases directly and mixes them into random traffic that often uses zero register fields. On every cycle it compares all outputs with a behavioural model, which must show the trap with cause 1, no write strobe, and zeroed result and index.

// File: rtl/rx_pkg.sv
`timescale 1ns/1ps
package rx_pkg;
    localparam int XLEN      = 32;
    localparam int RIDX_W    = 5;
    localparam int OPC_W     = 6;
    localparam int CLS_W     = 3;
    localparam int IMM_W     = 16;
    localparam int SHAMT_W   = $clog2(XLEN);
    localparam int OPC_LSB   = XLEN - OPC_W;
    localparam int FA_LSB    = OPC_LSB - RIDX_W;
    localparam int FB_LSB    = FA_LSB - RIDX_W;
    localparam int FC_LSB    = FB_LSB - RIDX_W;

    localparam logic [CLS_W-1:0] CLS_ARITH = 3'd0;
    localparam logic [CLS_W-1:0] CLS_LOGIC = 3'd1;
    localparam logic [CLS_W-1:0] CLS_MOVE  = 3'd2;
    localparam logic [CLS_W-1:0] CLS_MISC  = 3'd7;

    typedef enum logic [1:0] {
        TRAP_MISALIGN = 2'd0,
        TRAP_DIVZERO  = 2'd1,
        TRAP_SYSCALL  = 2'd2,
        TRAP_ILLEGAL  = 2'd3
    } trap_e;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_DIV  = 4'd3,
        OP_MOD  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_NOR  = 4'd10,
        OP_IMM  = 4'd11,
        OP_NONE = 4'd12
    } alu_op_e;

    typedef struct packed {
        alu_op_e                 op;
        logic [RIDX_W-1:0]       rd;
        logic [RIDX_W-1:0]       rs_b;
        logic [RIDX_W-1:0]       rs_c;
        logic [XLEN-1:0]         imm;
        logic                    is_sys;
        logic                    is_illegal;
    } decoded_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction
endpackage

// File: rtl/rx_decode.sv
`timescale 1ns/1ps
module rx_decode
    import rx_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output decoded_t        dec_o
);
    localparam int SUB_W = OPC_W - CLS_W;

    logic [CLS_W-1:0]  cls;
    logic [SUB_W-1:0]  sub;
    logic [RIDX_W-1:0] fa, fb, fc;

    assign cls = instr_i[XLEN-1 -: CLS_W];
    assign sub = instr_i[OPC_LSB +: SUB_W];
    assign fa  = instr_i[FA_LSB +: RIDX_W];
    assign fb  = instr_i[FB_LSB +: RIDX_W];
    assign fc  = instr_i[FC_LSB +: RIDX_W];

    always_comb begin
        dec_o            = '0;
        dec_o.op         = OP_NONE;
        dec_o.imm        = sext_imm(instr_i[IMM_W-1:0]);
        dec_o.is_sys     = 1'b0;
        dec_o.is_illegal = 1'b0;
        case (cls)
            CLS_ARITH: begin
                if (sub != 3'd7) begin
                    dec_o.op   = alu_op_e'({1'b0, sub});
                    dec_o.rd   = fa;
                    dec_o.rs_b = fb;
                    dec_o.rs_c = fc;
                end else begin
                    dec_o.is_illegal = 1'b1;
                end
            end
            CLS_LOGIC: begin
                if (sub[2] == 1'b0) begin
                    dec_o.op   = alu_op_e'(4'd7 + {2'b00, sub[1:0]});
                    dec_o.rd   = fa;
                    dec_o.rs_b = fb;
                    dec_o.rs_c = fc;
                end else begin
                    dec_o.is_illegal = 1'b1;
                end
            end
            CLS_MOVE: begin
                if (sub == 3'd0) begin
                    dec_o.op = OP_IMM;
                    dec_o.rd = fb;
                end else begin
                    dec_o.is_illegal = 1'b1;
                end
            end
            CLS_MISC: begin
                if (sub == 3'd0) dec_o.is_sys = 1'b1;
                else             dec_o.is_illegal = 1'b1;
            end
            default: dec_o.is_illegal = 1'b1;
        endcase
    end

    always_comb begin
        if (!$isunknown(instr_i)) begin
            // R9: system opcode classified as such and nothing else
            p_sys_class_r9: assert (!(instr_i[XLEN-1 -: OPC_W] == 6'o70) ||
                                    (dec_o.is_sys && !dec_o.is_illegal && dec_o.op == OP_NONE))
                else $error("sys opcode misclassified");
            // R10: an illegal opcode selects no operation
            p_illegal_idle_r10: assert (!dec_o.is_illegal || (dec_o.op == OP_NONE && !dec_o.is_sys))
                else $error("illegal opcode selected an operation");
        end
    end
endmodule

// File: rtl/rx_operand_gate.sv
`timescale 1ns/1ps
module rx_operand_gate
    import rx_pkg::*;
#(
    parameter int NPORTS = 2
)(
    input  logic [NPORTS-1:0][RIDX_W-1:0] idx_i,
    input  logic [NPORTS-1:0][XLEN-1:0]   val_i,
    output logic [NPORTS-1:0][XLEN-1:0]   val_o
);
    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assign val_o[g] = (idx_i[g] == '0) ? '0 : val_i[g];

        always_comb begin
            if (!$isunknown(idx_i[g])) begin
                // R7: register zero supplies zero
                p_zero_reg_reads_zero_r7: assert (idx_i[g] != '0 || val_o[g] == '0)
                    else $error("register 0 operand not zero");
            end
        end
    end
endmodule

// File: rtl/rx_alu.sv
`timescale 1ns/1ps
module rx_alu
    import rx_pkg::*;
(
    input  alu_op_e         op_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [XLEN-1:0] opc_i,
    input  logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] res_o,
    output logic            div_fault_o
);
    logic [SHAMT_W-1:0] shamt;
    logic               divisor_zero;
    logic [XLEN-1:0]    quot, rem;
    logic [2*XLEN-1:0]  prod;

    assign shamt        = opc_i[SHAMT_W-1:0];
    assign divisor_zero = (opc_i == '0);
    assign quot         = divisor_zero ? '0 : (opb_i / opc_i);
    assign rem          = divisor_zero ? '0 : (opb_i % opc_i);
    assign prod         = opb_i * opc_i;

    always_comb begin
        res_o       = '0;
        div_fault_o = 1'b0;
        case (op_i)
            OP_ADD: res_o = opb_i + opc_i;
            OP_SUB: res_o = opb_i - opc_i;
            OP_MUL: res_o = prod[XLEN-1:0];
            OP_DIV: begin
                res_o       = quot;
                div_fault_o = divisor_zero;
            end
            OP_MOD: begin
                res_o       = rem;
                div_fault_o = divisor_zero;
            end
            OP_SHL: res_o = opb_i << shamt;
            OP_SHR: res_o = opb_i >> shamt;
            OP_AND: res_o = opb_i & opc_i;
            OP_OR:  res_o = opb_i | opc_i;
            OP_XOR: res_o = opb_i ^ opc_i;
            OP_NOR: res_o = ~(opb_i | opc_i);
            OP_IMM: res_o = imm_i;
            default: res_o = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_i, opb_i, opc_i})) begin
            // R3: zero divisor on divide/remainder must fault
            p_zero_divisor_faults_r3: assert (!((op_i == OP_DIV || op_i == OP_MOD) && opc_i == '0) || div_fault_o)
                else $error("zero divisor without fault");
            // R3: remainder is below a non-zero divisor
            p_rem_bound_r3: assert (!(op_i == OP_MOD && opc_i != '0) || res_o < opc_i)
                else $error("remainder out of range");
            // R4: logical right shift never grows the value
            p_shr_shrinks_r4: assert (!(op_i == OP_SHR) || res_o <= opb_i)
                else $error("right shift grew the value");
        end
    end
endmodule

// File: rtl/risc_exec_stage.sv
`timescale 1ns/1ps
module risc_exec_stage
    import rx_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_b_val_i,
    input  logic [31:0] rs_c_val_i,
    output logic [4:0]  dst_idx_o,
    output logic        wr_en_o,
    output logic [31:0] result_o,
    output logic        trap_o,
    output logic [1:0]  trap_cause_o
);
    localparam int NSRC = 2;

    decoded_t                     dec;
    logic [NSRC-1:0][RIDX_W-1:0]  src_idx;
    logic [NSRC-1:0][XLEN-1:0]    src_raw, src_val;
    logic [XLEN-1:0]              alu_res;
    logic                         div_fault;
    logic                         any_trap;
    trap_e                        cause;

    rx_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    assign src_idx = {dec.rs_c, dec.rs_b};
    assign src_raw = {rs_c_val_i, rs_b_val_i};

    rx_operand_gate #(.NPORTS(NSRC)) u_gate (
        .idx_i (src_idx),
        .val_i (src_raw),
        .val_o (src_val)
    );

    rx_alu u_alu (
        .op_i        (dec.op),
        .opb_i       (src_val[0]),
        .opc_i       (src_val[1]),
        .imm_i       (dec.imm),
        .res_o       (alu_res),
        .div_fault_o (div_fault)
    );

    always_comb begin
        cause = TRAP_MISALIGN;
        if (dec.is_illegal)  cause = TRAP_ILLEGAL;
        else if (dec.is_sys) cause = TRAP_SYSCALL;
        else if (div_fault)  cause = TRAP_DIVZERO;
    end

    assign any_trap     = dec.is_illegal | dec.is_sys | div_fault;
    assign trap_o       = any_trap;
    assign trap_cause_o = cause;
    assign wr_en_o      = !any_trap && (dec.op != OP_NONE) && (dec.rd != '0);
    assign result_o     = wr_en_o ? alu_res : '0;
    assign dst_idx_o    = wr_en_o ? dec.rd : '0;

    always_comb begin
        if (!$isunknown({instr_i, rs_b_val_i, rs_c_val_i})) begin
            // R8: register zero is never written
            p_no_write_r0_r8: assert (!wr_en_o || dst_idx_o != '0)
                else $error("write strobe on register 0");
            // R10: any trap suppresses the write
            p_trap_blocks_write_r10: assert (!(trap_o && wr_en_o))
                else $error("write during trap");
            // R11: quiet outputs when idle
            p_quiet_outputs_r11: assert (wr_en_o || (result_o == '0 && dst_idx_o == '0))
                else $error("result or index non-zero without write");
            p_quiet_cause_r11: assert (trap_o || trap_cause_o == 2'd0)
                else $error("cause non-zero without trap");
            // R6: a written move carries the sign of the immediate
            p_move_sext_r6: assert (!(wr_en_o && instr_i[31:26] == 6'o20) ||
                                    result_o[31:16] == {16{instr_i[15]}})
                else $error("move not sign-extended");
        end
    end
endmodule

// File: tb/risc_exec_stage_bench.sv
`timescale 1ns/1ps
module risc_exec_stage_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr, bval, cval;
    logic [4:0]  dst;
    logic        wr, trap;
    logic [31:0] res;
    logic [1:0]  cause;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    risc_exec_stage u_risc_exec_stage (
        .instr_i      (instr),
        .rs_b_val_i   (bval),
        .rs_c_val_i   (cval),
        .dst_idx_o    (dst),
        .wr_en_o      (wr),
        .result_o     (res),
        .trap_o       (trap),
        .trap_cause_o (cause)
    );

    typedef struct {
        logic [31:0] ins;
        logic [31:0] b;
        logic [31:0] c;
        string       tag;
    } vec_t;

    vec_t q[$];

    function automatic logic [31:0] mk(int op, int a, int b, int c);
        return (32'(op) << 26) | (32'(a & 31) << 21) | (32'(b & 31) << 16) | (32'(c & 31) << 11);
    endfunction

    function automatic logic [31:0] mkimm(int op, int b, int imm);
        return (32'(op) << 26) | (32'(b & 31) << 16) | 32'(imm & 16'hFFFF);
    endfunction

    function automatic string tag_of(logic [5:0] op);
        case (op)
            6'o0, 6'o1, 6'o2: return "R2";
            6'o3, 6'o4:       return "R3";
            6'o5, 6'o6:       return "R4";
            6'o10, 6'o11, 6'o12, 6'o13: return "R5";
            6'o20:            return "R6";
            6'o70:            return "R9";
            default:          return "R10";
        endcase
    endfunction

    // behavioural reference
    task automatic model(input logic [31:0] ins, input logic [31:0] bv, input logic [31:0] cv,
                         output logic [4:0] e_dst, output logic e_wr, output logic [31:0] e_res,
                         output logic e_trap, output logic [1:0] e_cause);
        int unsigned op = ins[31:26];
        logic [4:0]  fa = ins[25:21];
        logic [4:0]  fb = ins[20:16];
        logic [4:0]  fc = ins[15:11];
        logic [31:0] x = (fb == 0) ? 32'd0 : bv;
        logic [31:0] y = (fc == 0) ? 32'd0 : cv;
        logic [63:0] p;
        logic [31:0] r = 0;
        logic [4:0]  d = fa;
        logic        t = 0;
        logic [1:0]  k = 0;
        logic        valid = 1;
        case (op)
            0: r = x + y;
            1: r = x - y;
            2: begin p = {32'd0, x} * {32'd0, y}; r = p[31:0]; end
            3: if (y == 0) begin t = 1; k = 1; end else r = x / y;
            4: if (y == 0) begin t = 1; k = 1; end else r = x % y;
            5: r = x << y[4:0];
            6: r = x >> y[4:0];
            8: r = x & y;
            9: r = x | y;
            10: r = x ^ y;
            11: r = ~(x | y);
            16: begin d = fb; r = {{16{ins[15]}}, ins[15:0]}; end
            56: begin t = 1; k = 2; valid = 0; end
            default: begin t = 1; k = 3; valid = 0; end
        endcase
        e_trap  = t;
        e_cause = k;
        e_wr    = valid && !t && (d != 0);
        e_res   = e_wr ? r : 32'd0;
        e_dst   = e_wr ? d : 5'd0;
    endtask

    task automatic run_one(input vec_t v);
        logic [4:0]  e_dst;
        logic        e_wr, e_trap;
        logic [31:0] e_res;
        logic [1:0]  e_cause;
        @(posedge clk);
        instr = v.ins; bval = v.b; cval = v.c;
        @(negedge clk);
        model(v.ins, v.b, v.c, e_dst, e_wr, e_res, e_trap, e_cause);
        total++;
        if (wr !== e_wr || dst !== e_dst || res !== e_res || trap !== e_trap || cause !== e_cause) begin
            bad++;
            $display("FAIL %s ins=%h b=%h c=%h: got wr=%0b dst=%0d res=%h trap=%0b cause=%0d exp wr=%0b dst=%0d res=%h trap=%0b cause=%0d",
                     v.tag, v.ins, v.b, v.c, wr, dst, res, trap, cause, e_wr, e_dst, e_res, e_trap, e_cause);
        end
    endtask

    task automatic add_vec(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] c, input string t);
        vec_t v;
        v.ins = ins; v.b = b; v.c = c; v.tag = t;
        q.push_back(v);
    endtask

    initial begin
        instr = 0; bval = 0; cval = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero word targets register 0 (R8, R11)
        add_vec(32'd0, 32'hFFFF_FFFF, 32'h1234_5678, "R8 reset/idle");
        // R1 field positions
        add_vec(mk(6'o0, 7, 3, 4), 32'd10, 32'd20, "R1 add r7");
        add_vec(mk(6'o0, 31, 30, 29), 32'h8000_0000, 32'h1, "R1 high fields");
        // R2 wrap
        add_vec(mk(6'o0, 1, 2, 3), 32'hFFFF_FFFF, 32'd2, "R2 add wrap");
        add_vec(mk(6'o1, 1, 2, 3), 32'd1, 32'd2, "R2 sub wrap");
        add_vec(mk(6'o2, 1, 2, 3), 32'h0001_0001, 32'h0001_0001, "R2 mul low bits");
        // R3
        add_vec(mk(6'o3, 5, 2, 3), 32'd100, 32'd7, "R3 div");
        add_vec(mk(6'o4, 5, 2, 3), 32'd100, 32'd7, "R3 mod");
        add_vec(mk(6'o3, 5, 2, 3), 32'd100, 32'd0, "R3 div zero");
        add_vec(mk(6'o4, 5, 2, 3), 32'd100, 32'd0, "R3 mod zero");
        add_vec(mk(6'o3, 5, 2, 0), 32'd100, 32'd9, "R3 R7 divisor from r0");
        add_vec(mk(6'o3, 0, 2, 3), 32'd100, 32'd0, "R3 R8 div zero into r0");
        add_vec(mk(6'o3, 6, 0, 3), 32'd55, 32'd4, "R7 dividend from r0");
        // R4
        add_vec(mk(6'o5, 1, 2, 3), 32'h0000_0001, 32'd35, "R4 shl low5");
        add_vec(mk(6'o6, 1, 2, 3), 32'h8000_0000, 32'd31, "R4 shr logical");
        // R5
        add_vec(mk(6'o10, 1, 2, 3), 32'hF0F0_F0F0, 32'hFF00_FF00, "R5 and");
        add_vec(mk(6'o11, 1, 2, 3), 32'hF0F0_F0F0, 32'h0F00_0000, "R5 or");
        add_vec(mk(6'o12, 1, 2, 3), 32'hF0F0_F0F0, 32'hFFFF_0000, "R5 xor");
        add_vec(mk(6'o13, 1, 2, 3), 32'hF0F0_0000, 32'h0000_000F, "R5 nor");
        // R6
        add_vec(mkimm(6'o20, 9, 16'h7FFF), 0, 0, "R6 move positive");
        add_vec(mkimm(6'o20, 9, 16'h8000), 0, 0, "R6 move negative");
        add_vec(mkimm(6'o20, 0, 16'h1234), 0, 0, "R6 R8 move to r0");
        // R7
        add_vec(mk(6'o11, 4, 0, 0), 32'hDEAD_BEEF, 32'hCAFE_F00D, "R7 both sources r0");
        // R8
        add_vec(mk(6'o0, 0, 2, 3), 32'd1, 32'd1, "R8 add into r0");
        // R9
        add_vec(32'o70 << 26, 0, 0, "R9 syscall");
        add_vec((32'o70 << 26) | 32'h03FF_FFFF, 32'h5, 32'h5, "R9 syscall with fields");
        // R10
        add_vec(mk(6'o7, 1, 2, 3), 1, 1, "R10 arith gap");
        add_vec(mk(6'o14, 1, 2, 3), 1, 1, "R10 logic gap");
        add_vec(mk(6'o21, 1, 2, 3), 1, 1, "R10 load form");
        add_vec(mk(6'o31, 1, 2, 3), 1, 1, "R10 branch form");
        add_vec(mk(6'o40, 1, 2, 3), 1, 1, "R10 jump form");
        add_vec(mk(6'o71, 1, 2, 3), 1, 1, "R10 misc gap");
        add_vec(32'hFFFF_FFFF, 1, 1, "R10 all ones");
        // random traffic, many zero fields
        for (int i = 0; i < 600; i++) begin
            logic [5:0] op;
            int pick = $urandom_range(0, 15);
            logic [31:0] w;
            logic [31:0] cv;
            case (pick)
                0,1,2,3,4,5,6: op = 6'(pick);
                7,8,9,10:      op = 6'(pick + 1);
                11:            op = 6'o20;
                12:            op = 6'o70;
                default:       op = 6'($urandom_range(0, 63));
            endcase
            w = $urandom();
            if ($urandom_range(0, 3) == 0) w[20:16] = 5'd0;
            if ($urandom_range(0, 3) == 0) w[15:11] = 5'd0;
            if ($urandom_range(0, 5) == 0) w[25:21] = 5'd0;
            w[31:26] = op;
            cv = ($urandom_range(0, 4) == 0) ? 32'd0 : $urandom();
            add_vec(w, $urandom(), cv, tag_of(op));
        end
        while (q.size() > 0) run_one(q.pop_front());
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired: got cycles=%0d exp under 50000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule